// File: doc/BRIEF.md
# Mode-Configurable Segmented Step Sequencer

This block is a ten-step pattern generator. Each step holds one bit, and the ten bits together form the output pattern. Each step also has a two-bit mode field. The modes cut the chain into independent sections that sit in series. A section can be one of three kinds:

- a binary ripple counter;
- a rotating shift register;
- a shift register that fills with alternating bits.

On each master tick the whole chain settles in a single combinational ripple, from step 1 to the last step. The first section advances on every tick. Each later section advances only when the final step of the section before it falls from 1 to 0. Only that trigger passes between sections; data does not.

Steps in the BREAK and RESET modes keep their bit in inverted form relative to the other modes. While step 1 is in RESET mode, the pattern settles to a fixed starting shape and stays there. In that shape the BREAK and RESET steps read 1 and all other steps read 0. Moving a step between the inverted and non-inverted mode groups flips its visible bit, with no tick needed.

Top module: `seg_step_sequencer`

## Requirements
- R1: Mode field i sits at bits [2i+1:2i] of `step_mode_i`, with step 1 at i=0. The codes are 00 COUNT, 01 SHIFT, 10 BREAK and 11 RESET. Code 11 on steps 2 to 10 acts as COUNT. Code 01 on step 1 also acts as COUNT.
- R2: In a run of adjacent COUNT steps, the lowest step is the least significant bit. A higher step toggles on a tick exactly when the step below it falls from 1 to 0.
- R3: A BREAK step followed by SHIFT steps forms a rotating register. When triggered, every bit moves one step toward step 10, and the last SHIFT bit of the run wraps into the BREAK step.
- R4: A COUNT step followed by SHIFT steps forms an alternating register. When triggered, the COUNT step toggles and its old value shifts into the SHIFT steps.
- R5: The first section advances on every tick. A later section advances only when the last step of the section before it falls from 1 to 0.
- R6: When a COUNT run is followed directly by SHIFT steps, its final COUNT step is the head of the alternating section. For example, CCCCCCSSSS is a five-bit counter followed by a five-bit alternating section.
- R7: While step 1 is in RESET, the state settles to the following and stays there even with ticks: step 1 reads 1, BREAK steps read 1, all other steps read 0.
- R8: Moving a step between the group {BREAK, RESET} and the group {COUNT, SHIFT} inverts its visible bit at once, with no tick.
- R9: With `tick_en` low, the state does not change.
- R10: After `rst_n` is asserted, BREAK steps read 1 and all other steps read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Master tick: advances the sequencer on this clock edge |
| step_mode_i | input | 2*NUM_STEPS | Packed per-step mode fields |
| state_o | output | NUM_STEPS | Visible step states; bit 0 is step 1 |

## Verification
The embedded assertions check the following on every clock:
- the stored bits hold when there is no tick;
- the stored bits clear while RESET mode is held;
- step 1 toggles on every tick when it is a counter head;
- a counter step changes exactly when its lower neighbour falls;
- the decoded modes stay legal;
- the last step shifts and falls as it should.

Some behaviours need whole tick sequences to show, and only the bench scenarios cover them. These are:
- section partitioning;
- triggering between sections;
- the rotating wrap;
- the fill order of the alternating register;
- the 12-tick period of the BSSSSS pattern;
- the visible inversion when a mode changes.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    MODE_COUNT = 2'b00,
    MODE_SHIFT = 2'b01,
    MODE_BREAK = 2'b10,
    MODE_RESET = 2'b11
  } step_mode_e;
endpackage

// File: rtl/seq_mode_decode.sv
// Maps raw two-bit fields to legal per-step modes (R1) and derives the
// inversion mask used for the stored bits (R8).
module seq_mode_decode
  import seq_pkg::*;
#(
  parameter int NUM_STEPS = 10
) (
  input  logic [2*NUM_STEPS-1:0] mode_fields,
  output step_mode_e             mode_q [NUM_STEPS],
  output logic [NUM_STEPS-1:0]   inv_mask,
  output logic                   hold_init
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_STEPS; gi++) begin : g_dec
      logic [1:0] fld;
      assign fld = mode_fields[2*gi +: 2];
      if (gi == 0) begin : g_head
        always_comb begin
          case (fld)
            2'b10:   mode_q[gi] = MODE_BREAK;
            2'b11:   mode_q[gi] = MODE_RESET;
            default: mode_q[gi] = MODE_COUNT;
          endcase
        end
      end else begin : g_body
        always_comb begin
          case (fld)
            2'b01:   mode_q[gi] = MODE_SHIFT;
            2'b10:   mode_q[gi] = MODE_BREAK;
            default: mode_q[gi] = MODE_COUNT;
          endcase
        end
      end
      assign inv_mask[gi] = (mode_q[gi] == MODE_BREAK) || (mode_q[gi] == MODE_RESET);

      // R1: decoded modes are legal for their position
      always_comb begin
        if (gi == 0) assert_head_legal_R1: assert (mode_q[gi] != MODE_SHIFT);
        else         assert_body_legal_R1: assert (mode_q[gi] != MODE_RESET);
      end
    end
  endgenerate

  assign hold_init = (mode_q[0] == MODE_RESET);
endmodule

// File: rtl/seq_wrap_scan.sv
// For each step, returns the old visible bit at the end of the SHIFT run
// that follows it (its own bit when no SHIFT follows). A BREAK step loads it.
module seq_wrap_scan
  import seq_pkg::*;
#(
  parameter int NUM_STEPS = 10
) (
  input  step_mode_e           mode_q [NUM_STEPS],
  input  logic [NUM_STEPS-1:0] vis,
  output logic [NUM_STEPS-1:0] tail_bit
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_STEPS; gi++) begin : g_scan
      if (gi == NUM_STEPS - 1) begin : g_end
        assign tail_bit[gi] = vis[gi];
      end else begin : g_mid
        assign tail_bit[gi] = (mode_q[gi+1] == MODE_SHIFT) ? tail_bit[gi+1] : vis[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/seq_step_cell.sv
// One step of the ripple: produces the next visible bit and the trigger and
// shift-enable passed on to the following step.
module seq_step_cell
  import seq_pkg::*;
(
  input  step_mode_e mode,
  input  logic       cur,
  input  logic       prev_cur,
  input  logic       tail,
  input  logic       trig_in,
  input  logic       shen_in,
  output logic       nxt,
  output logic       trig_out,
  output logic       shen_out
);
  always_comb begin
    nxt      = cur;
    shen_out = shen_in;
    trig_out = 1'b0;
    case (mode)
      MODE_COUNT: begin
        if (trig_in) nxt = ~cur;
        shen_out = trig_in;
        trig_out = cur & ~nxt;
      end
      MODE_SHIFT: begin
        if (shen_in) nxt = prev_cur;
        trig_out = cur & ~nxt;
      end
      MODE_BREAK: begin
        if (trig_in) nxt = tail;
        shen_out = trig_in;
        trig_out = cur & ~nxt;
      end
      default: begin
        nxt      = 1'b1;
        shen_out = 1'b0;
        trig_out = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/seq_state_reg.sv
// Reset synchroniser and the raw per-step storage.
module seq_state_reg #(
  parameter int NUM_STEPS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 clr,
  input  logic [NUM_STEPS-1:0] raw_d,
  output logic [NUM_STEPS-1:0] raw_q,
  output logic                 rst_ok_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_ok_n = sync_q[1];

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)   raw_q <= '0;
    else if (load)   raw_q <= raw_d;
  end

  // R9: no tick and no init hold leaves the stored bits untouched
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!load && !clr) |=> $stable(raw_q));
endmodule

// File: rtl/seg_step_sequencer.sv
module seg_step_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_STEPS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic [2*NUM_STEPS-1:0] step_mode_i,
  output logic [NUM_STEPS-1:0]   state_o
);
  localparam int LAST = NUM_STEPS - 1;

  step_mode_e           mode_q [NUM_STEPS];
  logic [NUM_STEPS-1:0] inv_mask;
  logic                 hold_init;
  logic [NUM_STEPS-1:0] raw_q, raw_d, vis, vis_nx, tail_bit;
  logic [NUM_STEPS:0]   trig_c, shen_c;
  logic                 load, rst_ok_n;

  seq_mode_decode #(.NUM_STEPS(NUM_STEPS)) u_dec (
    .mode_fields (step_mode_i),
    .mode_q      (mode_q),
    .inv_mask    (inv_mask),
    .hold_init   (hold_init)
  );

  assign vis = raw_q ^ inv_mask;

  seq_wrap_scan #(.NUM_STEPS(NUM_STEPS)) u_scan (
    .mode_q   (mode_q),
    .vis      (vis),
    .tail_bit (tail_bit)
  );

  assign trig_c[0] = 1'b1;
  assign shen_c[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_STEPS; gi++) begin : g_step
      logic prev_cur;
      if (gi == 0) begin : g_first
        assign prev_cur = 1'b0;
      end else begin : g_rest
        assign prev_cur = vis[gi-1];
      end
      seq_step_cell u_cell (
        .mode     (mode_q[gi]),
        .cur      (vis[gi]),
        .prev_cur (prev_cur),
        .tail     (tail_bit[gi]),
        .trig_in  (trig_c[gi]),
        .shen_in  (shen_c[gi]),
        .nxt      (vis_nx[gi]),
        .trig_out (trig_c[gi+1]),
        .shen_out (shen_c[gi+1])
      );

      if (gi > 0) begin : g_carry_chk
        // R2: a counter step above a counter step changes exactly when the lower one falls
        assert_count_carry_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
          (tick_en && !hold_init && mode_q[gi] == MODE_COUNT && mode_q[gi-1] == MODE_COUNT)
          |=> ((raw_q[gi] != $past(raw_q[gi])) == ($past(raw_q[gi-1]) && !raw_q[gi-1])));
      end
    end
  endgenerate

  // next-state: stored form is visible XOR inversion mask; init hold clears all
  always_comb begin
    raw_d = hold_init ? '0 : (vis_nx ^ inv_mask);
    load  = tick_en | hold_init;
  end

  seq_state_reg #(.NUM_STEPS(NUM_STEPS)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .clr      (hold_init),
    .raw_d    (raw_d),
    .raw_q    (raw_q),
    .rst_ok_n (rst_ok_n)
  );

  assign state_o = vis;

  // R7: while step 1 is in RESET the stored bits are cleared
  assert_init_clear_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    hold_init |=> (raw_q == '0));

  // R5: a counting first step toggles on every tick
  assert_head_toggle_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (tick_en && !hold_init && mode_q[0] == MODE_COUNT) |=> (raw_q[0] != $past(raw_q[0])));

  // R5: a trigger leaving the last step means it fell on that tick
  assert_tail_fall_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (tick_en && !hold_init && trig_c[NUM_STEPS]) |=>
    ($past(vis[LAST]) && !(raw_q[LAST] ^ $past(inv_mask[LAST]))));

  // R3: an enabled shift at the last step takes the neighbour's old bit
  assert_tail_shift_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (tick_en && !hold_init && shen_c[LAST] && shen_c[NUM_STEPS] && mode_q[LAST] == MODE_SHIFT) |=>
    ((raw_q[LAST] ^ $past(inv_mask[LAST])) == $past(vis[LAST-1])));
endmodule

// File: tb/seg_step_sequencer_tb_top.sv
module seg_step_sequencer_tb_top;
  localparam int N = 10;

  logic           clk;
  logic           rst_n;
  logic           tick_en;
  logic [2*N-1:0] step_mode_i;
  logic [N-1:0]   state_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  seg_step_sequencer #(.NUM_STEPS(N)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .step_mode_i (step_mode_i),
    .state_o     (state_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // stimulus / expectation table; state bit 0 is step 1, mode field 0 is step 1
  typedef struct packed {
    logic [2*N-1:0] modes;
    logic [7:0]     ticks;
    logic [N-1:0]   exp;
    logic [3:0]     req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{20'h00000, 8'd0,  10'b0000000000, 4'd10}, // R10 all counter, reset state
    '{20'h00002, 8'd0,  10'b0000000001, 4'd10}, // R10 break head reads 1 after reset
    '{20'h00000, 8'd5,  10'b0000000101, 4'd2},  // R2 ten-bit counter at 5
    '{20'h00030, 8'd5,  10'b0000000101, 4'd1},  // R1 code 11 on step 3 acts as COUNT
    '{20'h00001, 8'd5,  10'b0000000101, 4'd1},  // R1 code 01 on step 1 acts as COUNT
    '{20'b00_00_00_00_00_00_01_01_01_10, 8'd5,  10'b0000010010, 4'd3}, // R3 BSSSCCCCCC
    '{20'b00_00_00_00_01_01_01_01_01_10, 8'd12, 10'b0010000001, 4'd5}, // R5 BSSSSSCCCC
    '{20'b01_01_01_01_01_01_01_01_01_00, 8'd3,  10'b0000000101, 4'd4}, // R4 CSSSSSSSSS
    '{20'b01_01_01_01_00_00_00_00_00_00, 8'd32, 10'b0000100000, 4'd6}, // R6 CCCCCCSSSS
    '{20'b01_10_00_01_01_10_01_01_01_11, 8'd3,  10'b0100010001, 4'd7}  // R7 RSSSBSSCBS
  };

  function automatic logic [1:0] norm(input logic [2*N-1:0] m, input int i);
    logic [1:0] c;
    c = m[2*i +: 2];
    if (i == 0 && c == 2'b01) c = 2'b00;
    if (i != 0 && c == 2'b11) c = 2'b00;
    return c;
  endfunction

  function automatic logic [N-1:0] start_of(input logic [2*N-1:0] m);
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = norm(m, i)[1];
    return s;
  endfunction

  // behavioural step-by-step reference taken from the requirement text
  function automatic logic [N-1:0] model_next(input logic [2*N-1:0] m, input logic [N-1:0] s);
    logic [N-1:0] nv;
    logic df, sh, pv;
    logic [1:0] c;
    int b;
    nv = s; df = 1'b1; sh = 1'b1; pv = 1'b0;
    for (int i = 0; i < N; i++) begin
      c = norm(m, i);
      case (c)
        2'b00: begin pv = s[i]; if (df) nv[i] = ~s[i]; sh = df; end
        2'b01: begin if (sh) nv[i] = pv; pv = s[i]; end
        2'b10: begin
          pv = s[i];
          if (df) begin
            b = i + 1;
            while (b < N && norm(m, b) == 2'b01) b++;
            nv[i] = s[b-1];
          end
          sh = df;
        end
        default: begin nv[i] = 1'b1; sh = 1'b0; df = 1'b0; end
      endcase
      if (c != 2'b11) df = (pv != nv[i]) && !nv[i];
    end
    return nv;
  endfunction

  function automatic logic [2*N-1:0] enc(input string s);
    logic [2*N-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) begin
      case (s[i])
        "S": m[2*i +: 2] = 2'b01;
        "B": m[2*i +: 2] = 2'b10;
        "R": m[2*i +: 2] = 2'b11;
        default: m[2*i +: 2] = 2'b00;
      endcase
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests = n_tests + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2*N-1:0] m);
    @(negedge clk);
    tick_en = 1'b0;
    step_mode_i = m;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic walk(input string name, input int n);
    logic [2*N-1:0] m;
    logic [N-1:0] ref_s;
    m = enc(name);
    do_reset(m);
    ref_s = start_of(m);
    check("R10 walk start", state_o, ref_s);
    for (int k = 0; k < n; k++) begin
      run_ticks(1);
      ref_s = model_next(m, ref_s);
      check("R5 walk", state_o, ref_s);
    end
  endtask

  initial begin
    logic [N-1:0] snap;
    rst_n = 1'b0;
    tick_en = 1'b0;
    step_mode_i = '0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_reset(VECS[v].modes);
      run_ticks(int'(VECS[v].ticks));
      n_tests = n_tests + 1;
      if (state_o !== VECS[v].exp) begin
        n_fail = n_fail + 1;
        $display("FAIL R%0d vec %0d: actual=%b expected=%b", VECS[v].req, v, state_o, VECS[v].exp);
      end
    end

    // R3 / R5: BSSSSS head section has a 12-tick period in its low six bits plus step 7
    do_reset(enc("BSSSSSCCCC"));
    snap = state_o;
    run_ticks(12);
    check("R3 period 12", {3'b000, state_o[6:0]}, {3'b000, snap[6:0]});
    run_ticks(6);
    check("R3 wrap at tick 18", {3'b000, state_o[6:0]}, 10'b0001000001);

    // R4: alternating register saturates and then flips between two patterns
    do_reset(enc("CSSSSSSSSS"));
    run_ticks(10);
    snap = state_o;
    run_ticks(1);
    check("R4 alt flip", state_o, ~snap);
    run_ticks(1);
    check("R4 alt return", state_o, snap);

    // R9: no tick, no change
    do_reset(enc("CCCBSSSCSS"));
    run_ticks(9);
    snap = state_o;
    repeat (6) @(negedge clk);
    check("R9 hold", state_o, snap);

    // R8: group change inverts visible bit without a tick
    do_reset(20'h00000);
    run_ticks(5);
    step_mode_i = 20'h00002;
    @(negedge clk);
    check("R8 step1 to BREAK", state_o, 10'b0000000100);
    step_mode_i = 20'h0000A;
    @(negedge clk);
    check("R8 step2 to BREAK", state_o, 10'b0000000110);
    step_mode_i = 20'h00008;
    @(negedge clk);
    check("R8 step1 back to COUNT", state_o, 10'b0000000111);

    // R7: entering RESET mid-run forces the init pattern
    step_mode_i = enc("RSSSBSSCBS");
    run_ticks(2);
    check("R7 init from running", state_o, 10'b0100010001);

    // R10: asynchronous reset mid-run
    do_reset(enc("BCCCCCCCCC"));
    run_ticks(7);
    rst_n = 1'b0;
    #1;
    check("R10 async clear", state_o, 10'b0000000001);
    rst_n = 1'b1;

    // model walks across section layouts (R2 R3 R4 R5 R6)
    walk("CCCBSSSCSS", 60);
    walk("BSSSSSCCCC", 40);
    walk("CCCCCCSSSS", 70);
    walk("BSSBSCCSSS", 50);
    walk("CSSCCBSSCS", 50);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule